// File: doc/BRIEF.md
# Decode-Stage Data-Hazard Interlock

This block sits beside the decode stage of a five-stage in-order pipeline (fetch, decode, execute, memory, writeback). It looks at the instruction currently held in decode and checks its source registers against the destination registers of the instructions in execute and memory. When a source would be read before the older instruction has written it, the block holds the program counter and the fetch/decode pipe register in place and clears the decode/execute pipe register, so a harmless empty slot moves down the pipe instead of the dependent instruction. When no such conflict exists, every pipe register simply loads its next value.

The block has no state and needs no clock. Its outputs are one two-bit command per pipe register, which the surrounding pipe registers apply at their next clock edge. Forwarding is not used: a dependent instruction waits in decode until its producer reaches writeback. The register file writes early in a cycle and reads late, so a producer in writeback is already visible to decode.

Top module: `hazard_interlock`

## Requirements
- R1: When neither source register of the decode instruction matches a live destination in execute or memory, all five commands are transfer (00).
- R2: When the first source, instruction bits 25:21, equals a live execute destination, the fetch and decode commands are stall (01), the execute command is bubble (10), and the memory and writeback commands are transfer (00).
- R3: When the first source equals a live memory destination, the same stall/stall/bubble/transfer/transfer pattern of R2 is produced.
- R4: The second source, bits 20:16, is compared only when bit 12 is 0 (register-register form). With bit 12 set, bits 20:13 are an 8-bit literal, and a match there causes no stall.
- R5: Register 31 reads as zero, so a destination of 31 in execute or memory never causes a stall.
- R6: A destination whose valid bit is 0 never causes a stall.
- R7: The memory and writeback commands are always transfer, and no command ever takes the code 11.
- R8: In a pipeline that applies the commands, an instruction that reads the result of the instruction just ahead of it spends exactly two extra cycles in decode. All instructions retire in program order.
- R9: When there is one unrelated instruction between producer and consumer, the consumer spends exactly one extra cycle in decode.
- R10: When the producer is already in writeback as the consumer sits in decode, the consumer does not stall.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| id_instr | input | 32 | Instruction word held in the decode stage |
| ex_dst | input | 5 | Destination register of the instruction in execute |
| ex_vld | input | 1 | Execute slot holds a real instruction |
| mem_dst | input | 5 | Destination register of the instruction in memory |
| mem_vld | input | 1 | Memory slot holds a real instruction |
| cmd_fetch | output | 2 | Command for the program counter |
| cmd_decode | output | 2 | Command for the fetch/decode pipe register |
| cmd_execute | output | 2 | Command for the decode/execute pipe register |
| cmd_memory | output | 2 | Command for the execute/memory pipe register |
| cmd_writeback | output | 2 | Command for the memory/writeback pipe register |

## Verification
The hardest situation to reach from the ports is the two-cycle wait: the same dependent instruction must be held in decode while its producer advances from execute into memory, and a bubble must replace it in execute each time. The stall must also end exactly when the producer reaches writeback. A small pipeline model in the bench applies the commands to real pipe registers, so short programs with the consumer at distance one, two and three from the producer produce these sequences. The bench counts the stall cycles and the order in which instructions retire. Direct port tests cover the literal-form case in which bits 20:16 happen to equal a live destination.

// File: rtl/hazard_interlock.sv
module hazard_interlock #(
  parameter int REG_W    = 5,
  parameter int ZERO_REG = 31
) (
  input  logic [31:0]      id_instr,
  input  logic [REG_W-1:0] ex_dst,
  input  logic             ex_vld,
  input  logic [REG_W-1:0] mem_dst,
  input  logic             mem_vld,
  output logic [1:0]       cmd_fetch,
  output logic [1:0]       cmd_decode,
  output logic [1:0]       cmd_execute,
  output logic [1:0]       cmd_memory,
  output logic [1:0]       cmd_writeback
);
  localparam logic [1:0] XFER  = 2'b00;
  localparam logic [1:0] HOLD  = 2'b01;
  localparam logic [1:0] CLEAR = 2'b10;
  localparam int SRC_A_LO = 21;
  localparam int SRC_B_LO = 16;
  localparam int FORM_BIT = 12;
  localparam logic [REG_W-1:0] ZR = REG_W'(ZERO_REG);

  logic [REG_W-1:0] src_a, src_b;
  logic             reads_b, ex_live, mem_live, hit_ex, hit_mem, conflict;

  assign src_a   = id_instr[SRC_A_LO +: REG_W];
  assign src_b   = id_instr[SRC_B_LO +: REG_W];
  assign reads_b = ~id_instr[FORM_BIT];

  assign ex_live  = ex_vld  && (ex_dst  != ZR);
  assign mem_live = mem_vld && (mem_dst != ZR);

  assign hit_ex  = ex_live  && ((src_a == ex_dst)  || (reads_b && src_b == ex_dst));
  assign hit_mem = mem_live && ((src_a == mem_dst) || (reads_b && src_b == mem_dst));
  assign conflict = hit_ex || hit_mem;

  assign cmd_fetch     = conflict ? HOLD  : XFER;
  assign cmd_decode    = conflict ? HOLD  : XFER;
  assign cmd_execute   = conflict ? CLEAR : XFER;
  assign cmd_memory    = XFER;
  assign cmd_writeback = XFER;

  logic unused_bits;
  assign unused_bits = &{1'b0, id_instr[31:26], id_instr[15:13], id_instr[11:0]};
endmodule

module hazard_interlock_chk (
  input logic [31:0] id_instr,
  input logic [4:0]  ex_dst,
  input logic        ex_vld,
  input logic [4:0]  mem_dst,
  input logic        mem_vld,
  input logic [1:0]  cmd_fetch,
  input logic [1:0]  cmd_decode,
  input logic [1:0]  cmd_execute,
  input logic [1:0]  cmd_memory,
  input logic [1:0]  cmd_writeback
);
  logic known, quiet;
  assign known = !$isunknown({id_instr, ex_dst, ex_vld, mem_dst, mem_vld});
  assign quiet = (!ex_vld || ex_dst == 5'd31) && (!mem_vld || mem_dst == 5'd31);

  always_comb begin
    if (known) begin
      p_back_xfer_r7: assert (cmd_memory == 2'b00 && cmd_writeback == 2'b00)
        else $error("memory/writeback not transfer");
      p_no_code3_r7: assert (cmd_fetch != 2'b11 && cmd_decode != 2'b11 && cmd_execute != 2'b11)
        else $error("illegal command code");
      p_freeze_pair_r2: assert (cmd_fetch == cmd_decode)
        else $error("fetch and decode disagree");
      p_bubble_with_hold_r3: assert ((cmd_execute == 2'b10) == (cmd_decode == 2'b01))
        else $error("bubble not paired with stall");
      p_quiet_writers_r5: assert (!quiet || cmd_decode == 2'b00)
        else $error("stall without live writer");
      p_invalid_r6: assert (ex_vld || mem_vld || cmd_execute == 2'b00)
        else $error("stall with both slots empty");
    end
  end
endmodule

bind hazard_interlock hazard_interlock_chk u_chk (.*);

// File: tb/hazard_interlock_test.sv
module hazard_interlock_test;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  logic        pipe_mode = 1'b0;
  logic [31:0] m_instr = '0;
  logic [4:0]  m_ex = '0, m_mem = '0;
  logic        m_exv = 1'b0, m_memv = 1'b0;

  logic [31:0] imem [0:7];
  logic [3:0]  pc;
  logic [31:0] ifid, idex, exmem, memwb;

  logic [31:0] id_instr;
  logic [4:0]  ex_dst, mem_dst;
  logic        ex_vld, mem_vld;
  logic [1:0]  cmd_fetch, cmd_decode, cmd_execute, cmd_memory, cmd_writeback;

  assign id_instr = pipe_mode ? ifid        : m_instr;
  assign ex_dst   = pipe_mode ? idex[4:0]   : m_ex;
  assign ex_vld   = pipe_mode ? (idex != 0) : m_exv;
  assign mem_dst  = pipe_mode ? exmem[4:0]  : m_mem;
  assign mem_vld  = pipe_mode ? (exmem != 0): m_memv;

  hazard_interlock uut (
    .id_instr(id_instr), .ex_dst(ex_dst), .ex_vld(ex_vld),
    .mem_dst(mem_dst), .mem_vld(mem_vld),
    .cmd_fetch(cmd_fetch), .cmd_decode(cmd_decode), .cmd_execute(cmd_execute),
    .cmd_memory(cmd_memory), .cmd_writeback(cmd_writeback)
  );

  function automatic logic [31:0] step(input logic [1:0] c, input logic [31:0] cur, input logic [31:0] nxt);
    case (c)
      2'b00:   return nxt;
      2'b10:   return 32'h0;
      default: return cur;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (!pipe_mode) begin
      pc <= '0; ifid <= '0; idex <= '0; exmem <= '0; memwb <= '0;
    end else begin
      if (cmd_fetch == 2'b00) pc <= pc + 4'd1;
      ifid  <= step(cmd_decode, ifid, (pc < 4'd8) ? imem[pc[2:0]] : 32'h0);
      idex  <= step(cmd_execute, idex, ifid);
      exmem <= step(cmd_memory, exmem, idex);
      memwb <= step(cmd_writeback, memwb, exmem);
    end
  end

  function automatic logic [31:0] enc_rr(input logic [4:0] a, input logic [4:0] b, input logic [4:0] d);
    return {6'h10, a, b, 3'b000, 1'b0, 7'h20, d};
  endfunction
  function automatic logic [31:0] enc_ri(input logic [4:0] a, input logic [7:0] lit, input logic [4:0] d);
    return {6'h11, a, lit, 1'b1, 7'h20, d};
  endfunction

  localparam logic [9:0] ALL_XFER = 10'b00_00_00_00_00;
  localparam logic [9:0] FREEZE   = 10'b01_01_10_00_00;

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic drive(input logic [31:0] ins, input logic [4:0] ed, input logic ev,
                       input logic [4:0] md, input logic mv, input logic [9:0] exp, input string req);
    @(negedge clk);
    m_instr = ins; m_ex = ed; m_exv = ev; m_mem = md; m_memv = mv;
    #1;
    chk(req, {22'd0, cmd_fetch, cmd_decode, cmd_execute, cmd_memory, cmd_writeback}, {22'd0, exp});
  endtask

  task automatic t_idle;
    drive(32'h0, 5'd0, 1'b0, 5'd0, 1'b0, ALL_XFER, "R1 empty pipe");
    drive(enc_rr(5'd1, 5'd2, 5'd3), 5'd4, 1'b1, 5'd5, 1'b1, ALL_XFER, "R1 no match");
  endtask

  task automatic t_ex_a;
    drive(enc_rr(5'd4, 5'd2, 5'd3), 5'd4, 1'b1, 5'd5, 1'b1, FREEZE, "R2 src A vs execute");
    drive(enc_ri(5'd9, 8'd0, 5'd1), 5'd9, 1'b1, 5'd0, 1'b0, FREEZE, "R2 literal form src A");
  endtask

  task automatic t_mem_a;
    drive(enc_rr(5'd5, 5'd2, 5'd3), 5'd4, 1'b1, 5'd5, 1'b1, FREEZE, "R3 src A vs memory");
  endtask

  task automatic t_src_b;
    drive(enc_rr(5'd1, 5'd4, 5'd3), 5'd4, 1'b1, 5'd5, 1'b1, FREEZE, "R4 src B vs execute");
    drive(enc_rr(5'd1, 5'd5, 5'd3), 5'd4, 1'b1, 5'd5, 1'b1, FREEZE, "R4 src B vs memory");
    drive(enc_ri(5'd1, {5'd4, 3'b111}, 5'd3), 5'd4, 1'b1, 5'd4, 1'b1, ALL_XFER, "R4 literal ignored");
  endtask

  task automatic t_zero;
    drive(enc_rr(5'd31, 5'd31, 5'd3), 5'd31, 1'b1, 5'd31, 1'b1, ALL_XFER, "R5 register 31");
  endtask

  task automatic t_invalid;
    drive(enc_rr(5'd4, 5'd5, 5'd3), 5'd4, 1'b0, 5'd5, 1'b0, ALL_XFER, "R6 invalid slots");
    drive(enc_rr(5'd4, 5'd5, 5'd3), 5'd4, 1'b0, 5'd5, 1'b1, FREEZE, "R6 one valid slot");
  endtask

  task automatic run_prog(input string req, input int n, input int exp_stalls);
    int stalls = 0;
    int ret = 0;
    @(negedge clk);
    pipe_mode = 1'b0;
    @(negedge clk);
    pipe_mode = 1'b1;
    for (int c = 0; c < 16; c++) begin
      @(negedge clk);
      if (cmd_decode == 2'b01) stalls++;
      if (cmd_memory != 2'b00 || cmd_writeback != 2'b00)
        chk({req, " R7 back stages"}, {cmd_memory, cmd_writeback}, 0);
      if (memwb != 0) begin
        if (ret < n) chk({req, " order"}, memwb, imem[ret]);
        ret++;
      end
    end
    chk({req, " stalls"}, stalls, exp_stalls);
    chk({req, " retired"}, ret, n);
    pipe_mode = 1'b0;
  endtask

  task automatic clear_imem;
    for (int i = 0; i < 8; i++) imem[i] = 32'h0;
  endtask

  task automatic t_dist1;
    clear_imem();
    imem[0] = enc_ri(5'd31, 8'd7, 5'd2);
    imem[1] = enc_ri(5'd2, 8'd0, 5'd3);
    imem[2] = enc_ri(5'd2, 8'd0, 5'd4);
    run_prog("R8 distance one", 3, 2);
  endtask

  task automatic t_dist2;
    clear_imem();
    imem[0] = enc_ri(5'd31, 8'd7, 5'd2);
    imem[1] = enc_ri(5'd31, 8'd1, 5'd5);
    imem[2] = enc_rr(5'd2, 5'd31, 5'd6);
    run_prog("R9 distance two", 3, 1);
  endtask

  task automatic t_dist3;
    clear_imem();
    imem[0] = enc_ri(5'd31, 8'd7, 5'd2);
    imem[1] = enc_ri(5'd31, 8'd1, 5'd5);
    imem[2] = enc_ri(5'd31, 8'd1, 5'd6);
    imem[3] = enc_rr(5'd31, 5'd2, 5'd7);
    run_prog("R10 writer in writeback", 4, 0);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    #200000;
    tests++;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    clear_imem();
    repeat (2) @(negedge clk);
    t_idle();
    t_ex_a();
    t_mem_a();
    t_src_b();
    t_zero();
    t_invalid();
    t_dist1();
    t_dist2();
    t_dist3();
    finish_run();
  end
endmodule